// File: doc/BRIEF.md
# Event Timer Register File

This block is the register front end of a multi-channel event timer. A simple request/response slave port carries a byte address, an access length of 1, 2, 4 or 8 bytes, write data and a write flag. One cycle later it returns read data and an error flag. Behind the port sit a read-only capability word, a two-bit general configuration register, a free-running 64-bit main counter and, for each channel, a configuration, a comparator and a routing register.

Every register is 64 bits wide. Narrow accesses work through a byte-lane mask: a narrow read returns the addressed lanes shifted down to bit 0, and a narrow write replaces only the addressed lanes and keeps the rest. The main counter advances once per clock while the global enable bit is set. Clearing the bit freezes the count, and setting it again resumes from the frozen value. Each legal write to a channel register raises a one-cycle strobe for that channel and that register, so the comparator and delivery logic outside can react. That outside logic also reads the channel registers from dedicated outputs.

Top module: `evt_regfile`

## Requirements
- R1: A request is legal only when the length is 1, 2, 4 or 8 and the low three address bits are a multiple of the length. An illegal request responds with `rsp_err`=1. An illegal read returns all ones. An illegal write changes no register and raises no strobe.
- R2: A legal read of L bytes at address A returns the 64-bit register at A rounded down to 8, shifted right by 8·(A mod 8) bits and masked to 8·L bits. The response appears in the cycle after the request.
- R3: A legal write of L bytes at A replaces byte lanes A mod 8 through A mod 8 + L − 1 with the low L bytes of `req_wdata`. All other lanes keep their old value. A write response carries zero data.
- R4: At offset 0x010 only bits 1:0 can be written: bit 0 is the global enable and bit 1 the legacy routing select. The other bits read as zero. `gen_cfg_o` changes only on a write.
- R5: With the enable set, the main counter (offset 0x0F0) rises by one on every clock. With the enable clear, it holds its value, and it resumes from that value when re-enabled.
- R6: The main counter accepts writes whether or not it is enabled. A written value counts on from the next cycle and wraps modulo 2^64.
- R7: Offset 0x000 reads as the capability word. Its low half is 0x8086A201 for three channels: bits 12:8 hold the channel count minus one, bit 13 marks a 64-bit counter, bit 15 marks legacy routing. Its high half is the tick period in femtoseconds (default 4000000), so a 4-byte read at 0x004 returns the period. Writes to it are ignored.
- R8: Channel n's configuration sits at 0x100+0x20·n. It resets to 0x00F00000_00000030, and only the bits in mask 0x3F4E can be written.
- R9: Channel n's comparator (+0x08) resets to all ones and its route (+0x10) to zero. Both are fully writable.
- R10: Status (0x020), unused offsets below 0x100, the fourth slot of each channel and everything at or above 0x100+0x20·channels (0x160) read as zero. Writes there change nothing.
- R11: Address bits above bit 9 are ignored, so the 1 KiB window repeats.
- R12: A legal write to channel n's configuration, comparator or route raises bit n of `ch_cfg_we`, `ch_cmp_we` or `ch_route_we` for exactly the response cycle. At most one strobe is high at a time.
- R13: After reset the general configuration and the main counter are zero, and the channel registers hold their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address (bits above 9 ignored) |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read data, right-aligned |
| rsp_err | output | 1 | Previous request was illegal |
| gen_cfg_o | output | 2 | Bit 0 enable, bit 1 legacy routing |
| counter_o | output | 64 | Main counter value |
| ch_cfg_o | output | NUM_CH·64 | Channel configurations, channel 0 lowest |
| ch_cmp_o | output | NUM_CH·64 | Channel comparators |
| ch_route_o | output | NUM_CH·64 | Channel routing words |
| ch_cfg_we | output | NUM_CH | Configuration write strobes |
| ch_cmp_we | output | NUM_CH | Comparator write strobes |
| ch_route_we | output | NUM_CH | Routing write strobes |

## Verification
The merge and extract paths are driven with full-width, half, word and single-byte accesses at several lane offsets of one comparator. A lane error then shows up as a wrong byte in a known pattern rather than as a plausible value. Misaligned, odd-length, zero-length and oversize requests are mixed with legal ones, and each is followed by a read-back, which separates a dropped write from a merged one. The counter is checked across enable, disable and re-enable, and across a write made while it runs that wraps past 2^64. These cases separate freezing from resetting and write priority from increment. Aliased addresses above the 1 KiB window and accesses to holes and beyond the last channel tell decode width apart from decode range.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int WIN_BITS = 10;

    typedef logic [63:0] word_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP,
        SEL_GCFG,
        SEL_CNT,
        SEL_CCFG,
        SEL_CCMP,
        SEL_CROUTE
    } sel_e;

    typedef struct packed {
        logic       legal;
        sel_e       sel;
        logic [4:0] ch;
        logic [2:0] lane;
        logic [3:0] len;
    } dec_t;

    localparam word_t CH_CFG_WMASK = 64'h0000_0000_0000_3F4E;
    localparam word_t CH_CFG_RESET = 64'h00F0_0000_0000_0030;
    localparam word_t CH_CMP_RESET = '1;

    function automatic word_t len_mask(logic [3:0] len);
        word_t m;
        case (len)
            4'd1:    m = 64'h0000_0000_0000_00FF;
            4'd2:    m = 64'h0000_0000_0000_FFFF;
            4'd4:    m = 64'h0000_0000_FFFF_FFFF;
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic word_t lane_mask(logic [2:0] lane, logic [3:0] len);
        return len_mask(len) << {lane, 3'b000};
    endfunction

    function automatic word_t merge_lanes(word_t oldv, word_t wd,
                                          logic [2:0] lane, logic [3:0] len);
        word_t m;
        m = lane_mask(lane, len);
        return ((wd << {lane, 3'b000}) & m) | (oldv & ~m);
    endfunction

    function automatic word_t extract_lanes(word_t v, logic [2:0] lane,
                                            logic [3:0] len);
        return (v >> {lane, 3'b000}) & len_mask(len);
    endfunction

    function automatic logic access_legal(logic [2:0] lane, logic [3:0] len);
        logic ok;
        case (len)
            4'd1:    ok = 1'b1;
            4'd2:    ok = (lane[0] == 1'b0);
            4'd4:    ok = (lane[1:0] == 2'b00);
            4'd8:    ok = (lane == 3'b000);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/evt_access_decode.sv
module evt_access_decode
    import evt_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [WIN_BITS-1:0] off,
    input  logic [3:0]          len,
    output dec_t                dec
);

    logic [4:0] blk;
    logic [4:0] chan_idx;

    assign blk      = off[9:5];
    assign chan_idx = blk - 5'd8;

    always_comb begin
        dec       = '0;
        dec.sel   = SEL_NONE;
        dec.lane  = off[2:0];
        dec.len   = len;
        dec.legal = access_legal(off[2:0], len);
        if (off[9:8] == 2'b00) begin
            case (off[7:3])
                5'h00:   dec.sel = SEL_CAP;
                5'h02:   dec.sel = SEL_GCFG;
                5'h1E:   dec.sel = SEL_CNT;
                default: dec.sel = SEL_NONE;
            endcase
        end else if (int'(chan_idx) < NUM_CH) begin
            dec.ch = chan_idx;
            case (off[4:3])
                2'd0:    dec.sel = SEL_CCFG;
                2'd1:    dec.sel = SEL_CCMP;
                2'd2:    dec.sel = SEL_CROUTE;
                default: dec.sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
    import evt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  wr_en,
    input  word_t wr_val,
    output word_t cnt
);

    word_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q <= wr_val;
        end else if (run) begin
            cnt_q <= cnt_q + 64'd1;
        end
    end

    assign cnt = cnt_q;

    // R5: running counter advances by one
    a_r5_counts: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && !$past(wr_en)) |-> cnt_q == $past(cnt_q) + 64'd1);

    // R5: stopped counter holds
    a_r5_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(run) && !$past(wr_en)) |-> $stable(cnt_q));

    // R6: written value lands regardless of enable
    a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cnt_q == $past(wr_val));

    // R13: reset clears the count
    a_r13_reset_zero: assert property (@(posedge clk)
        rst |=> cnt_q == '0);

endmodule

// File: rtl/evt_channel_regs.sv
module evt_channel_regs
    import evt_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  sel_e                    sel,
    input  logic [4:0]              ch,
    input  word_t                   wd,
    output logic [NUM_CH-1:0][63:0] cfg_q,
    output logic [NUM_CH-1:0][63:0] cmp_q,
    output logic [NUM_CH-1:0][63:0] route_q,
    output logic [NUM_CH-1:0]       cfg_we,
    output logic [NUM_CH-1:0]       cmp_we,
    output logic [NUM_CH-1:0]       route_we
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = wr_en && (ch == 5'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g]    <= CH_CFG_RESET;
                cmp_q[g]    <= CH_CMP_RESET;
                route_q[g]  <= '0;
                cfg_we[g]   <= 1'b0;
                cmp_we[g]   <= 1'b0;
                route_we[g] <= 1'b0;
            end else begin
                cfg_we[g]   <= hit && (sel == SEL_CCFG);
                cmp_we[g]   <= hit && (sel == SEL_CCMP);
                route_we[g] <= hit && (sel == SEL_CROUTE);
                if (hit && sel == SEL_CCFG)
                    cfg_q[g] <= (wd & CH_CFG_WMASK) | (cfg_q[g] & ~CH_CFG_WMASK);
                if (hit && sel == SEL_CCMP)
                    cmp_q[g] <= wd;
                if (hit && sel == SEL_CROUTE)
                    route_q[g] <= wd;
            end
        end

        // R8: read-only configuration bits never move
        a_r8_cfg_ro_bits: assert property (@(posedge clk) disable iff (rst)
            ((cfg_q[g] & ~CH_CFG_WMASK) == ($past(cfg_q[g]) & ~CH_CFG_WMASK)));
    end

    // R12: at most one channel register written per cycle
    a_r12_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cfg_we, cmp_we, route_we}));

endmodule

// File: rtl/evt_regfile.sv
module evt_regfile
    import evt_pkg::*;
#(
    parameter int          NUM_CH    = 3,
    parameter int          ADDR_W    = 16,
    parameter int unsigned PERIOD_FS = 4000000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [3:0]           req_len,
    input  logic [63:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [63:0]          rsp_rdata,
    output logic                 rsp_err,
    output logic [1:0]           gen_cfg_o,
    output logic [63:0]          counter_o,
    output logic [NUM_CH*64-1:0] ch_cfg_o,
    output logic [NUM_CH*64-1:0] ch_cmp_o,
    output logic [NUM_CH*64-1:0] ch_route_o,
    output logic [NUM_CH-1:0]    ch_cfg_we,
    output logic [NUM_CH-1:0]    ch_cmp_we,
    output logic [NUM_CH-1:0]    ch_route_we
);

    localparam logic [4:0] CH_LAST = 5'(NUM_CH - 1);
    localparam word_t CAP_WORD = {32'(PERIOD_FS), 16'h8086,
                                  1'b1, 1'b0, 1'b1, CH_LAST, 8'h01};

    dec_t                    dec;
    word_t                   old_val;
    word_t                   merged;
    word_t                   cnt;
    logic                    wr_ok;
    logic                    rsp_wr;
    logic [1:0]              gcfg_q;
    logic [NUM_CH-1:0][63:0] cfg_q;
    logic [NUM_CH-1:0][63:0] cmp_q;
    logic [NUM_CH-1:0][63:0] route_q;
    logic                    unused_hi_addr;

    assign unused_hi_addr = ^req_addr[ADDR_W-1:WIN_BITS];

    evt_access_decode #(.NUM_CH(NUM_CH)) u_dec (
        .off (req_addr[WIN_BITS-1:0]),
        .len (req_len),
        .dec (dec)
    );

    always_comb begin
        old_val = '0;
        case (dec.sel)
            SEL_CAP:  old_val = CAP_WORD;
            SEL_GCFG: old_val = {62'b0, gcfg_q};
            SEL_CNT:  old_val = cnt;
            default:  old_val = '0;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (dec.ch == 5'(i)) begin
                if (dec.sel == SEL_CCFG)   old_val = cfg_q[i];
                if (dec.sel == SEL_CCMP)   old_val = cmp_q[i];
                if (dec.sel == SEL_CROUTE) old_val = route_q[i];
            end
        end
    end

    assign merged = merge_lanes(old_val, req_wdata, dec.lane, dec.len);
    assign wr_ok  = req_valid && req_write && dec.legal;

    evt_main_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (gcfg_q[0]),
        .wr_en  (wr_ok && dec.sel == SEL_CNT),
        .wr_val (merged),
        .cnt    (cnt)
    );

    evt_channel_regs #(.NUM_CH(NUM_CH)) u_ch (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_ok),
        .sel      (dec.sel),
        .ch       (dec.ch),
        .wd       (merged),
        .cfg_q    (cfg_q),
        .cmp_q    (cmp_q),
        .route_q  (route_q),
        .cfg_we   (ch_cfg_we),
        .cmp_we   (ch_cmp_we),
        .route_we (ch_route_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gcfg_q    <= 2'b00;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_wr    <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !dec.legal;
            rsp_wr    <= req_valid && req_write;
            if (!req_valid)
                rsp_rdata <= '0;
            else if (!dec.legal)
                rsp_rdata <= '1;
            else if (req_write)
                rsp_rdata <= '0;
            else
                rsp_rdata <= extract_lanes(old_val, dec.lane, dec.len);
            if (wr_ok && dec.sel == SEL_GCFG)
                gcfg_q <= merged[1:0];
        end
    end

    assign gen_cfg_o  = gcfg_q;
    assign counter_o  = cnt;
    assign ch_cfg_o   = cfg_q;
    assign ch_cmp_o   = cmp_q;
    assign ch_route_o = route_q;

    // R1: unsupported length always reports an error
    a_r1_bad_len_err: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(req_len inside {4'd1, 4'd2, 4'd4, 4'd8})) |=> rsp_err);

    // R1: illegal read answers all ones
    a_r1_err_read_ones: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err && !rsp_wr) |-> rsp_rdata == '1);

    // R1: rejected request raises no strobe
    a_r1_err_no_strobe: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> ({ch_cfg_we, ch_cmp_we, ch_route_we} == '0));

    // R4: configuration moves only after a write request
    a_r4_cfg_stable: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write) |=> $stable(gen_cfg_o));

endmodule

// File: tb/evt_regfile_test.sv
module evt_regfile_test;

    localparam int NCH = 3;
    localparam bit [63:0] CAP_EXP = 64'h003D_0900_8086_A201;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [15:0]       req_addr = '0;
    logic [3:0]        req_len = 4'd8;
    logic [63:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [63:0]       rsp_rdata;
    logic              rsp_err;
    logic [1:0]        gen_cfg_o;
    logic [63:0]       counter_o;
    logic [NCH*64-1:0] ch_cfg_o, ch_cmp_o, ch_route_o;
    logic [NCH-1:0]    ch_cfg_we, ch_cmp_we, ch_route_we;

    string req_tag = "";
    int    n_checks = 0;
    int    n_errors = 0;
    bit    started = 1'b0;

    always #2 clk = ~clk;

    evt_regfile uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .gen_cfg_o(gen_cfg_o), .counter_o(counter_o),
        .ch_cfg_o(ch_cfg_o), .ch_cmp_o(ch_cmp_o), .ch_route_o(ch_route_o),
        .ch_cfg_we(ch_cfg_we), .ch_cmp_we(ch_cmp_we), .ch_route_we(ch_route_we)
    );

    // reference model state
    bit [63:0] m_cnt, m_ccfg[NCH], m_ccmp[NCH], m_crt[NCH];
    bit [1:0]  m_gcfg;
    bit        exp_valid, exp_err;
    bit [63:0] exp_rd;
    bit [NCH-1:0] exp_cfg_we, exp_cmp_we, exp_rt_we;
    string     exp_tag;

    function automatic bit [63:0] m_reg(int unsigned base);
        int unsigned rel, n;
        if (base == 0)     return CAP_EXP;
        if (base == 'h10)  return {62'd0, m_gcfg};
        if (base == 'hF0)  return m_cnt;
        if (base >= 'h100 && base < 'h100 + 32 * NCH) begin
            rel = base - 'h100;
            n = rel / 32;
            case (rel % 32)
                0:  return m_ccfg[n];
                8:  return m_ccmp[n];
                16: return m_crt[n];
                default: return 64'd0;
            endcase
        end
        return 64'd0;
    endfunction

    int unsigned off_v, a_v, base_v, ln_v, rel_v, n_v;
    bit          legal_v;
    bit [63:0]   old_v, nv_v, nxt_cnt;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_gcfg = 0;
            for (int i = 0; i < NCH; i++) begin
                m_ccfg[i] = 64'h00F0_0000_0000_0030;
                m_ccmp[i] = '1;
                m_crt[i]  = 0;
            end
            exp_valid = 0; exp_err = 0; exp_rd = 0;
            exp_cfg_we = 0; exp_cmp_we = 0; exp_rt_we = 0;
        end else begin
            exp_valid = req_valid; exp_err = 0; exp_rd = 0; exp_tag = req_tag;
            exp_cfg_we = 0; exp_cmp_we = 0; exp_rt_we = 0;
            nxt_cnt = m_gcfg[0] ? m_cnt + 64'd1 : m_cnt;
            if (req_valid) begin
                off_v  = int'(req_addr) % 1024;
                a_v    = off_v % 8;
                base_v = off_v - a_v;
                ln_v   = int'(req_len);
                legal_v = (ln_v == 1 || ln_v == 2 || ln_v == 4 || ln_v == 8)
                          && (a_v % ln_v == 0);
                if (!legal_v) begin
                    exp_err = 1; exp_rd = '1;
                end else begin
                    old_v = m_reg(base_v);
                    if (!req_write) begin
                        for (int i = 0; i < ln_v; i++)
                            exp_rd[8*i +: 8] = old_v[8*(a_v+i) +: 8];
                    end else begin
                        nv_v = old_v;
                        for (int i = 0; i < ln_v; i++)
                            nv_v[8*(a_v+i) +: 8] = req_wdata[8*i +: 8];
                        if (base_v == 'h10) m_gcfg = nv_v[1:0];
                        if (base_v == 'hF0) nxt_cnt = nv_v;
                        if (base_v >= 'h100 && base_v < 'h100 + 32 * NCH) begin
                            rel_v = base_v - 'h100;
                            n_v = rel_v / 32;
                            if (rel_v % 32 == 0) begin
                                m_ccfg[n_v] = (nv_v & 64'h3F4E) | (m_ccfg[n_v] & ~64'h3F4E);
                                exp_cfg_we[n_v] = 1;
                            end
                            if (rel_v % 32 == 8) begin
                                m_ccmp[n_v] = nv_v; exp_cmp_we[n_v] = 1;
                            end
                            if (rel_v % 32 == 16) begin
                                m_crt[n_v] = nv_v; exp_rt_we[n_v] = 1;
                            end
                        end
                    end
                end
            end
            m_cnt = nxt_cnt;
        end
    end

    task automatic check(bit ok, string tag, bit [63:0] act, bit [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !rst) begin
            check(counter_o == m_cnt, "R5 R6 R13 counter", counter_o, m_cnt);
            check(gen_cfg_o == m_gcfg, "R4 general config", 64'(gen_cfg_o), 64'(m_gcfg));
            check({ch_cfg_we, ch_cmp_we, ch_route_we} == {exp_cfg_we, exp_cmp_we, exp_rt_we},
                  "R12 strobes", 64'({ch_cfg_we, ch_cmp_we, ch_route_we}),
                  64'({exp_cfg_we, exp_cmp_we, exp_rt_we}));
            for (int i = 0; i < NCH; i++) begin
                check(ch_cfg_o[64*i +: 64] == m_ccfg[i], "R8 channel config",
                      ch_cfg_o[64*i +: 64], m_ccfg[i]);
                check(ch_cmp_o[64*i +: 64] == m_ccmp[i], "R9 comparator",
                      ch_cmp_o[64*i +: 64], m_ccmp[i]);
                check(ch_route_o[64*i +: 64] == m_crt[i], "R9 route",
                      ch_route_o[64*i +: 64], m_crt[i]);
            end
            check(rsp_valid == exp_valid, "R2 response valid", 64'(rsp_valid), 64'(exp_valid));
            if (exp_valid) begin
                check(rsp_err == exp_err, {"R1 error flag ", exp_tag}, 64'(rsp_err), 64'(exp_err));
                check(rsp_rdata == exp_rd, exp_tag, rsp_rdata, exp_rd);
            end
        end
    end

    task automatic acc(bit wr, int unsigned addr, int unsigned len,
                       bit [63:0] wd, string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = 16'(addr);
        req_len   = 4'(len);
        req_wdata = wd;
        req_tag   = tag;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        started = 1'b1;
        // R13 reset state and R7 capability
        acc(0, 'h000, 8, 0, "R7 capability");
        acc(0, 'h004, 4, 0, "R7 period");
        acc(0, 'h000, 4, 0, "R7 capability low");
        acc(1, 'h000, 8, '1, "R7 write ignored");
        acc(0, 'h000, 8, 0, "R7 capability after write");
        acc(0, 'h010, 8, 0, "R13 config reset");
        acc(0, 'h0F0, 8, 0, "R13 counter reset");
        acc(0, 'h100, 8, 0, "R13 R8 channel config reset");
        acc(0, 'h148, 8, 0, "R9 comparator reset");
        // R8 writable mask
        acc(1, 'h100, 8, '1, "R8 config write");
        acc(0, 'h100, 8, 0, "R8 config readback");
        acc(1, 'h120, 2, 64'h0000, "R8 config narrow write");
        // R3 lane merge, R2 narrow reads
        acc(1, 'h128, 8, 64'h1122_3344_5566_7788, "R3 full write");
        acc(1, 'h12A, 2, 64'hABCD, "R3 half write");
        acc(1, 'h12F, 1, 64'hEE, "R3 byte write");
        acc(1, 'h12C, 4, 64'h0BAD_F00D, "R3 word write");
        acc(0, 'h128, 8, 0, "R3 merged readback");
        acc(0, 'h12B, 1, 0, "R2 byte read");
        acc(0, 'h12C, 4, 0, "R2 word read");
        acc(0, 'h12A, 2, 0, "R2 half read");
        acc(0, 'h129, 1, 0, "R2 odd byte read");
        // R1 illegal requests
        acc(0, 'h121, 2, 0, "R1 misaligned read");
        acc(1, 'h12C, 8, 64'h0, "R1 misaligned write");
        acc(1, 'h128, 3, 64'h0, "R1 odd length write");
        acc(0, 'h128, 0, 0, "R1 zero length read");
        acc(1, 'h128, 15, 64'h0, "R1 oversize write");
        acc(1, 'h136, 4, 64'h0, "R1 misaligned route write");
        acc(0, 'h128, 8, 0, "R1 unchanged after illegal writes");
        // R4 config, R5 counting
        acc(1, 'h010, 8, '1, "R4 enable and legacy");
        acc(0, 'h010, 8, 0, "R4 config readback");
        idle(10);
        acc(0, 'h0F0, 8, 0, "R5 running read");
        acc(1, 'h010, 1, 64'h2, "R4 R5 disable");
        idle(6);
        acc(0, 'h0F0, 8, 0, "R5 frozen read");
        acc(1, 'h010, 1, 64'h1, "R5 resume");
        idle(5);
        // R6 counter writes
        acc(1, 'h0F0, 8, 64'hFFFF_FFFF_FFFF_FFFA, "R6 write while running");
        idle(10);
        acc(0, 'h0F0, 8, 0, "R6 wrapped read");
        acc(1, 'h010, 8, 0, "R6 stop");
        acc(1, 'h0F4, 4, 64'h1234_5678, "R6 narrow write stopped");
        acc(0, 'h0F0, 8, 0, "R6 narrow readback");
        acc(0, 'h0F4, 4, 0, "R2 R6 upper half read");
        // R10 holes and out of range
        acc(1, 'h160, 8, '1, "R10 beyond last channel");
        acc(0, 'h160, 8, 0, "R10 beyond read");
        acc(1, 'h020, 8, '1, "R10 status write");
        acc(0, 'h020, 8, 0, "R10 status read");
        acc(1, 'h118, 8, '1, "R10 channel hole write");
        acc(0, 'h118, 8, 0, "R10 channel hole read");
        acc(0, 'h3F8, 8, 0, "R10 window top read");
        acc(0, 'h008, 8, 0, "R10 low hole read");
        // R11 aliasing
        acc(0, 'h528, 8, 0, "R11 alias read");
        acc(1, 'hD30, 8, 64'hCAFE_0000_0000_BEEF, "R11 alias route write");
        acc(0, 'h130, 8, 0, "R11 alias readback");
        // R12 strobes on each kind and channel
        acc(1, 'h150, 4, 64'h55, "R12 route ch2");
        acc(1, 'h148, 8, 64'h77, "R12 comparator ch2");
        acc(1, 'h140, 8, 64'h8, "R12 config ch2");
        acc(1, 'h108, 1, 64'h3, "R12 comparator ch0");
        acc(0, 'h150, 8, 0, "R12 read raises no strobe");
        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule